// File: doc/BRIEF.md
# Ascending 2-3 Smooth Number Generator

This block produces, in strictly ascending order and without repeats, every number of the form 2^i·3^j that does not exceed a bound chosen at start. It is a small feedback network. Each value leaves on an output stream and is also sent around two loops. One loop doubles the value and the other triples it, and each loop keeps its pending products in a small FIFO. An ordered merge looks at the head of both FIFOs and emits the smaller head. When the two heads are equal it emits the value once and drops both heads.

A `start` pulse empties both FIFOs and loads each with a single token of value 1, which gets the loop running. The same pulse captures the bound. Values then leave on a valid/ready stream. When the smallest pending value is above the captured bound, the block stops and raises `done`. The bound is at most 2^W-1, so generation also stops before any value would exceed the output width. If a product is pushed into a full branch FIFO, a sticky error flag is set.

Top module: `smooth_seq_gen`

## Requirements
- R1: After reset, `outValid`, `done` and `fifoErr` are all 0, and no value is offered until `start` is pulsed.
- R2: A `start` pulse, in any state, restarts generation. In the cycle after the pulse, `outValid` is 1 and `outData` is 1.
- R3: The accepted values are exactly the numbers 2^i·3^j, in strictly ascending order. The first eight accepted values are 1, 2, 3, 4, 6, 8, 9, 12.
- R4: A value reachable through both branches (6, 12, 18, ...) is emitted only once.
- R5: While `outValid` is 1 and `outReady` is 0, `outData` holds its value and the sequence does not advance.
- R6: Every 2-3 smooth value up to and including the captured bound is emitted. After the last one is accepted, `outValid` falls, and `done` rises one cycle later. `done` stays high and nothing more is offered until the next `start`. A bound of 0 emits nothing.
- R7: `limit` is sampled only in the cycle `start` is high. Changing it during a run does not change where the run stops.
- R8: With the bound at 2^W-1, the run ends after the largest 2-3 smooth number that fits in W bits (62208 for W=16), and no wider value is offered.
- R9: A push into a full branch FIFO sets `fifoErr`, which stays set until the next `start` clears it. A FIFO of the default depth never sets it, even with the largest bound.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse: seed both loops and capture the bound |
| limit | input | W | Largest value to generate, sampled with `start` |
| outReady | input | 1 | Consumer accepts `outData` this cycle |
| outValid | output | 1 | `outData` holds the next value of the sequence |
| outData | output | W | Current smallest pending value |
| done | output | 1 | All values up to the bound have been emitted |
| fifoErr | output | 1 | Sticky: a product was pushed into a full FIFO |

## Verification
The embedded properties assume that `start` is a clean single-cycle pulse and that the consumer changes `outReady` only between clock edges. Under those assumptions, a held value must stay put, consecutive accepted values must rise, and `done` must persist. The directed scenarios keep to this by driving every input on the falling edge. They restart only through `start`. They also check overflow only on a separate instance built with a deliberately tiny FIFO depth, so the ordering and stopping checks on the main instance never see corrupted loop state.

// File: rtl/smooth_pkg.sv
package smooth_pkg;

  // strobes from the control to the datapath
  typedef struct packed {
    logic init;   // flush both loops, seed tokens, capture bound
    logic take;   // current minimum is handed over this cycle
  } ctlStrobes_t;

  // conditions reported by the datapath to the control
  typedef struct packed {
    logic bothNonEmpty; // a head exists on each branch
    logic overLimit;    // smallest head is above the bound
  } dpStatus_t;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } genState_e;

endpackage

// File: rtl/smooth_fifo.sv
module smooth_fifo #(
  parameter int EW    = 18,
  parameter int DEPTH = 32
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          init,
  input  logic [EW-1:0] seed,
  input  logic          push,
  input  logic [EW-1:0] pushData,
  input  logic          pop,
  output logic [EW-1:0] head,
  output logic          notEmpty,
  output logic          overflow
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [EW-1:0] mem [DEPTH];
  logic [AW-1:0] rdPtr, wrPtr;
  logic [CW-1:0] cnt;
  logic          full, doPush;

  function automatic logic [AW-1:0] nextPtr(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  assign full     = (cnt == CW'(DEPTH));
  assign notEmpty = (cnt != '0);
  assign doPush   = push && (!full || pop);
  assign overflow = push && full && !pop;
  assign head     = mem[rdPtr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      wrPtr <= '0;
      cnt   <= '0;
    end else if (init) begin
      rdPtr <= '0;
      wrPtr <= AW'(1);
      cnt   <= CW'(1);
    end else begin
      if (doPush) wrPtr <= nextPtr(wrPtr);
      if (pop)    rdPtr <= nextPtr(rdPtr);
      cnt <= cnt + CW'(doPush) - CW'(pop);
    end
  end

  always_ff @(posedge clk) begin
    if (init)        mem[0]     <= seed;
    else if (doPush) mem[wrPtr] <= pushData;
  end

  // blocking read: a head is only consumed when it is present (R3)
  assert_pop_nonempty_R3: assert property (@(posedge clk) disable iff (!rstN)
    (pop && !init) |-> notEmpty);

endmodule

// File: rtl/smooth_datapath.sv
module smooth_datapath
  import smooth_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  ctlStrobes_t ctl,
  input  logic [W-1:0] limit,
  output dpStatus_t   stat,
  output logic [W-1:0] outData,
  output logic        fifoErr
);
  // two guard bits: every pushed product is at most 3x a value <= limit
  localparam int EW = W + 2;
  localparam int NB = 2;

  logic [EW-1:0] headV  [NB];
  logic [NB-1:0] nonEmp, ovf;
  logic [EW-1:0] minV;
  logic [W-1:0]  limitReg;

  assign minV = (headV[0] <= headV[1]) ? headV[0] : headV[1];

  for (genvar g = 0; g < NB; g++) begin : g_branch
    logic [EW-1:0] product;
    logic          popThis;
    // branch 0 doubles, branch 1 triples
    if (g == 0) begin : g_x2
      assign product = minV << 1;
    end else begin : g_x3
      assign product = minV + (minV << 1);
    end
    assign popThis = ctl.take && (headV[g] == minV);

    smooth_fifo #(.EW(EW), .DEPTH(DEPTH)) u_fifo (
      .clk      (clk),
      .rstN     (rstN),
      .init     (ctl.init),
      .seed     (EW'(1)),
      .push     (ctl.take),
      .pushData (product),
      .pop      (popThis),
      .head     (headV[g]),
      .notEmpty (nonEmp[g]),
      .overflow (ovf[g])
    );
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      limitReg <= '0;
      fifoErr  <= 1'b0;
    end else if (ctl.init) begin
      limitReg <= limit;
      fifoErr  <= 1'b0;
    end else if (|ovf) begin
      fifoErr  <= 1'b1;
    end
  end

  assign stat.bothNonEmpty = &nonEmp;
  assign stat.overLimit    = (minV > {2'b00, limitReg});
  assign outData           = minV[W-1:0];

  // a handed-over value never exceeds the captured bound (R6, R8)
  assert_take_within_limit_R6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.take |-> (minV <= {2'b00, limitReg}));

  // once set, the error flag persists until a restart (R9)
  assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (fifoErr && !ctl.init) |=> fifoErr);

endmodule

// File: rtl/smooth_control.sv
module smooth_control
  import smooth_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        outReady,
  input  dpStatus_t   stat,
  output ctlStrobes_t ctl,
  output logic        outValid,
  output logic        done
);
  genState_e state, stateNx;

  assign outValid = (state == ST_RUN) && stat.bothNonEmpty && !stat.overLimit;
  assign ctl.init = start;
  assign ctl.take = outValid && outReady && !start;
  assign done     = (state == ST_FIN);

  always_comb begin
    stateNx = state;
    if (start)
      stateNx = ST_RUN;
    else if (state == ST_RUN && stat.bothNonEmpty && stat.overLimit)
      stateNx = ST_FIN;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNx;
  end

  // done persists until the next start (R6)
  assert_done_holds_R6: assert property (@(posedge clk) disable iff (!rstN)
    (done && !start) |=> done);

  // nothing is offered after completion (R6)
  assert_quiet_when_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !outValid);

  // the cycle after a start always offers a value (R2)
  assert_start_offers_R2: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (state == ST_RUN));

endmodule

// File: rtl/smooth_seq_gen.sv
module smooth_seq_gen
  import smooth_pkg::*;
#(
  parameter int W     = 16,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] limit,
  input  logic         outReady,
  output logic         outValid,
  output logic [W-1:0] outData,
  output logic         done,
  output logic         fifoErr
);
  ctlStrobes_t ctl;
  dpStatus_t   stat;

  smooth_control u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .outReady (outReady),
    .stat     (stat),
    .ctl      (ctl),
    .outValid (outValid),
    .done     (done)
  );

  smooth_datapath #(.W(W), .DEPTH(DEPTH)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .limit   (limit),
    .stat    (stat),
    .outData (outData),
    .fifoErr (fifoErr)
  );

  // a stalled value is held (R5)
  assert_hold_stable_R5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && !outReady && !start) |=> (outValid && $stable(outData)));

  // consecutive accepted values rise strictly (R3, R4)
  assert_ascending_R3: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outReady && !start) |=> (start || !outValid || (outData > $past(outData))));

endmodule

// File: tb/sim_smooth_seq_gen.sv
`timescale 1ns/1ps
module sim_smooth_seq_gen;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0, outReady = 1'b0;
  logic [W-1:0] limit = '0;
  logic outValid, done, fifoErr;
  logic [W-1:0] outData;

  logic start1 = 1'b0;
  logic [W-1:0] limit1 = '0;
  logic outValid1, done1, fifoErr1;
  logic [W-1:0] outData1;

  int nChecks = 0, nFails = 0, cycles = 0;

  always #4 clk = ~clk;   // 125 MHz

  smooth_seq_gen #(.W(W), .DEPTH(32)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .limit(limit), .outReady(outReady),
    .outValid(outValid), .outData(outData), .done(done), .fifoErr(fifoErr));

  smooth_seq_gen #(.W(W), .DEPTH(2)) u1 (
    .clk(clk), .rstN(rstN), .start(start1), .limit(limit1), .outReady(1'b1),
    .outValid(outValid1), .outData(outData1), .done(done1), .fifoErr(fifoErr1));

  task automatic check(input string req, input longint act, input longint exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit isSmooth(input int n);
    int m = n;
    if (m < 1) return 0;
    while (m % 2 == 0) m = m / 2;
    while (m % 3 == 0) m = m / 3;
    return m == 1;
  endfunction

  function automatic int nextSmooth(input int x);
    int n = x + 1;
    while (!isSmooth(n)) n++;
    return n;
  endfunction

  task automatic pulseStart(input logic [W-1:0] lim);
    @(negedge clk); limit = lim; start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  // runs one generation; mode 0: always ready, 1: ready 2 of 3 cycles
  task automatic runSeq(input logic [W-1:0] lim, input logic [W-1:0] limLater,
                        input int mode, input string req);
    int exp = 1;
    int emitted = 0;
    int expCount = 0;
    int guard = 0;
    bit rdy;
    for (int v = 1; v <= int'(lim); v = nextSmooth(v)) expCount++;
    pulseStart(lim);
    limit = limLater;
    while (!done && guard < 5000) begin
      rdy = (mode == 0) ? 1'b1 : (guard % 3 != 2);
      outReady = rdy;
      if (outValid) begin
        check(req, outData, exp);
        if (rdy) begin exp = nextSmooth(exp); emitted++; end
      end
      guard++;
      @(negedge clk);
    end
    outReady = 1'b0;
    check({req, " done"}, done, 1);
    check({req, " count"}, emitted, expCount);
    check({req, " quiet"}, outValid, 0);
  endtask

  task automatic testReset();
    check("R1 valid", outValid, 0);
    check("R1 done", done, 0);
    check("R1 err", fifoErr, 0);
    repeat (3) @(negedge clk);
    check("R1 idle", outValid, 0);
  endtask

  task automatic testFirstValues();
    int ref8[8] = '{1, 2, 3, 4, 6, 8, 9, 12};
    pulseStart(16'd1000);
    check("R2 first valid", outValid, 1);
    check("R2 first data", outData, 1);
    outReady = 1'b1;
    for (int k = 0; k < 8; k++) begin
      check("R3 R4 prefix", outData, ref8[k]);
      @(negedge clk);
    end
    outReady = 1'b0;
    // restart mid-run
    pulseStart(16'd1000);
    check("R2 restart data", outData, 1);
    check("R2 restart valid", outValid, 1);
  endtask

  task automatic testBackpressure();
    pulseStart(16'd50);
    outReady = 1'b1;
    repeat (3) @(negedge clk);
    outReady = 1'b0;
    check("R5 stall data", outData, 4);
    repeat (4) @(negedge clk);
    check("R5 held data", outData, 4);
    check("R5 held valid", outValid, 1);
    outReady = 1'b1;
    @(negedge clk);
    check("R5 resume", outData, 6);
    outReady = 1'b0;
    runSeq(16'd200, 16'd200, 1, "R5 R3 stalled run");
  endtask

  task automatic testLimits();
    runSeq(16'd0, 16'd0, 0, "R6 zero bound");
    runSeq(16'd1, 16'd1, 0, "R6 bound one");
    runSeq(16'd108, 16'd108, 0, "R6 smooth bound");
    runSeq(16'd107, 16'd107, 0, "R6 between");
    runSeq(16'd20, 16'd5000, 0, "R7 bound change ignored");
    check("R9 no err default depth", fifoErr, 0);
  endtask

  task automatic testFullWidth();
    int lastSeen = 0;
    pulseStart(16'hFFFF);
    outReady = 1'b1;
    for (int g = 0; g < 2000 && !done; g++) begin
      if (outValid) lastSeen = outData;
      @(negedge clk);
    end
    outReady = 1'b0;
    check("R8 last value", lastSeen, 62208);
    check("R8 done", done, 1);
    check("R9 no err full width", fifoErr, 0);
  endtask

  task automatic testOverflow();
    check("R9 err clear at reset", fifoErr1, 0);
    @(negedge clk); limit1 = 16'd100; start1 = 1'b1;
    @(negedge clk); start1 = 1'b0;
    repeat (6) @(negedge clk);
    check("R9 err set", fifoErr1, 1);
    repeat (3) @(negedge clk);
    check("R9 err sticky", fifoErr1, 1);
    @(negedge clk); start1 = 1'b1;
    @(negedge clk); start1 = 1'b0;
    check("R9 err cleared by start", fifoErr1, 0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nChecks++; nFails++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testFirstValues();
    testBackpressure();
    testLimits();
    testFullWidth();
    testOverflow();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule